// File: doc/BRIEF.md
# GPIO Bank with Event Interrupts

This block is a 32-pin general-purpose I/O bank reached through a plain 32-bit register bus: a word address, a write strobe with write data, and read data that follows the address. Software picks the direction of each pin. It drives outputs from a data latch that can be written whole or changed bit by bit through write-one set and clear aliases. It reads inputs that have passed a two-flop synchronizer.

Each pin has four event detectors that can be enabled in any mix: input low, input high, rising edge and falling edge. Any detected event marks the pin pending in the raw status of both interrupt lines. Each line has its own enable mask, changed through write-one set and clear aliases, and its own write-one-to-clear status. An interrupt output is high while any pending pin of its line is also enabled. A fixed revision word identifies the block.

Top module: `pin_bank_ctrl`

## Requirements
- R1: The word at bus address 0x00 always reads 0x50600801, and writes to it change nothing.
- R2: The direction register at word address 0x4D resets to all ones. A 1 makes the pin an input, a 0 makes it an output, and `pad_oe_n` shows the register bit for bit.
- R3: The output latch at word 0x4F resets to 0 and takes direct writes. Writing to word 0x65 sets the latch bits where the data has 1s, and writing to word 0x64 clears them. Data bits of 0 leave the latch as it was. `pad_out` shows the latch.
- R4: Word 0x4E reads the input pins after a two-flop synchronizer, with bit p standing for pin p.
- R5: The detect enables are low level at word 0x50, high level at 0x51, rising edge at 0x52 and falling edge at 0x53. An edge is found by comparing the synchronized sample with the sample one cycle older.
- R6: The raw status words (0x09 for line 0, 0x0A for line 1) are set by every detected event, whatever the enables. The masked status words (0x0B, 0x0C) read raw AND enable. `irq_o[n]` is high while line n's masked status is nonzero.
- R7: Writing 1s to a masked status word clears those pending bits of that line only. Writing 0s does nothing, and writes to the raw status words are ignored.
- R8: While an enabled level condition holds, a cleared pending bit is set again on the next cycle. An event in the same cycle as a clear wins.
- R9: The enables of line n are set by writing 1s to word 0x0D+n and cleared by writing 1s to word 0x0F+n. Either word reads back the current mask of that line. The enables reset to 0.
- R10: Several detect types may be enabled for one pin at once, and their events are ORed. A new type can be enabled before the old one is removed, and an event is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Word address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Output latch driven to the pins |
| pad_oe_n | output | 32 | Per-pin direction, 1 = input |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
The detectors are driven with separate pins held in different states: a rising pin that then stays high, a falling pin, a pin held high under high-level detection, and a pin held low under low-level detection. These show whether an edge fires once and whether a level fires again after each clear. Interrupts are tried with enables on one line only, which separates raw from masked status and line 0 from line 1. Writes of zero words and writes to read-only words check that those writes change nothing. A pin is moved from edge detection to level detection, with the new type enabled before the old ones are removed, to show that no event is lost.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

    parameter int NPIN        = 32;
    parameter int ADDR_W      = 7;
    parameter int NLINE       = 2;
    parameter int SYNC_STAGES = 2;

    localparam logic [31:0] REV_VALUE = 32'h5060_0801;

    typedef logic [NPIN-1:0] pinvec_t;

    // Enables of the four detector kinds, one bit per pin
    typedef struct packed {
        pinvec_t lvl_lo;
        pinvec_t lvl_hi;
        pinvec_t rise;
        pinvec_t fall;
    } detect_cfg_t;

    // Synchronized sample and the sample one cycle older
    typedef struct packed {
        pinvec_t cur;
        pinvec_t prev;
    } sample_t;

    typedef enum logic [3:0] {
        RG_NONE, RG_REV, RG_OE, RG_DIN, RG_DOUT,
        RG_LLO, RG_LHI, RG_RISE, RG_FALL, RG_DCLR, RG_DSET
    } bank_reg_e;

    // Byte offset to word address
    function automatic logic [ADDR_W-1:0] wa(input int unsigned off);
        return ADDR_W'(off >> 2);
    endfunction

    localparam logic [ADDR_W-1:0] A_REV   = wa(32'h000);
    localparam logic [ADDR_W-1:0] A_RAW0  = wa(32'h024);
    localparam logic [ADDR_W-1:0] A_STS0  = wa(32'h02C);
    localparam logic [ADDR_W-1:0] A_ESET0 = wa(32'h034);
    localparam logic [ADDR_W-1:0] A_ECLR0 = wa(32'h03C);
    localparam logic [ADDR_W-1:0] A_OE    = wa(32'h134);
    localparam logic [ADDR_W-1:0] A_DIN   = wa(32'h138);
    localparam logic [ADDR_W-1:0] A_DOUT  = wa(32'h13C);
    localparam logic [ADDR_W-1:0] A_LLO   = wa(32'h140);
    localparam logic [ADDR_W-1:0] A_LHI   = wa(32'h144);
    localparam logic [ADDR_W-1:0] A_RISE  = wa(32'h148);
    localparam logic [ADDR_W-1:0] A_FALL  = wa(32'h14C);
    localparam logic [ADDR_W-1:0] A_DCLR  = wa(32'h190);
    localparam logic [ADDR_W-1:0] A_DSET  = wa(32'h194);

    function automatic bank_reg_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            A_REV:   return RG_REV;
            A_OE:    return RG_OE;
            A_DIN:   return RG_DIN;
            A_DOUT:  return RG_DOUT;
            A_LLO:   return RG_LLO;
            A_LHI:   return RG_LHI;
            A_RISE:  return RG_RISE;
            A_FALL:  return RG_FALL;
            A_DCLR:  return RG_DCLR;
            A_DSET:  return RG_DSET;
            default: return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync
    import pin_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t din,
    output sample_t smp
);

    pinvec_t stg [SYNC_STAGES];
    pinvec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[SYNC_STAGES-1];
        end
    end

    assign smp.cur  = stg[SYNC_STAGES-1];
    assign smp.prev = prev_q;

    // R5: the older sample is the synchronized sample of the cycle before
    assert_prev_tracks_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (smp.prev == $past(smp.cur)));

endmodule

// File: rtl/pin_bank_detect.sv
module pin_bank_detect
    import pin_bank_pkg::*;
(
    input  detect_cfg_t cfg,
    input  sample_t     smp,
    output pinvec_t     evt
);

    pinvec_t rise_hit, fall_hit, lo_hit, hi_hit;

    always_comb begin
        lo_hit   = cfg.lvl_lo & ~smp.cur;
        hi_hit   = cfg.lvl_hi &  smp.cur;
        rise_hit = cfg.rise   &  smp.cur & ~smp.prev;
        fall_hit = cfg.fall   & ~smp.cur &  smp.prev;
        evt      = lo_hit | hi_hit | rise_hit | fall_hit;
    end

endmodule

// File: rtl/pin_bank_irq_line.sv
module pin_bank_irq_line
    import pin_bank_pkg::*;
#(
    parameter int LINE = 0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  pinvec_t           wdata,
    input  pinvec_t           evt,
    output logic              rd_hit,
    output pinvec_t           rd_val,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(int'(A_RAW0)  + LINE);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(int'(A_STS0)  + LINE);
    localparam logic [ADDR_W-1:0] A_ES  = ADDR_W'(int'(A_ESET0) + LINE);
    localparam logic [ADDR_W-1:0] A_EC  = ADDR_W'(int'(A_ECLR0) + LINE);

    pinvec_t raw_q, en_q, masked;
    pinvec_t clr_w, en_set, en_clr;

    assign clr_w  = (wr && addr == A_STS) ? wdata : '0;
    assign en_set = (wr && addr == A_ES)  ? wdata : '0;
    assign en_clr = (wr && addr == A_EC)  ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_w) | evt;   // event wins over clear
            en_q  <= (en_q & ~en_clr) | en_set;
        end
    end

    assign masked = raw_q & en_q;
    assign irq    = |masked;

    always_comb begin
        rd_hit = 1'b1;
        case (addr)
            A_RAW:      rd_val = raw_q;
            A_STS:      rd_val = masked;
            A_ES, A_EC: rd_val = en_q;
            default: begin
                rd_hit = 1'b0;
                rd_val = '0;
            end
        endcase
    end

    // R7: a cleared bit with no event in that cycle is low afterwards
    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & $past(clr_w & ~evt)) == '0));

    // R8: an event always leaves its pending bit set
    assert_event_sets_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & $past(evt)) == $past(evt)));

    // R9: enable-set bits take effect on the next cycle
    assert_en_set_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((en_q & $past(en_set)) == $past(en_set)));

    // R6: line interrupt follows pending and enabled bits
    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pin_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe_n,
    output logic [NLINE-1:0]  irq_o
);

    bank_reg_e   sel;
    pinvec_t     oe_q, dout_q, evt, wd;
    detect_cfg_t cfg_q;
    sample_t     smp;

    logic    line_hit [NLINE];
    pinvec_t line_val [NLINE];

    assign sel = decode(bus_addr);
    assign wd  = bus_wdata[NPIN-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= '1;
            dout_q <= '0;
            cfg_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                RG_OE:   oe_q        <= wd;
                RG_DOUT: dout_q      <= wd;
                RG_DSET: dout_q      <= dout_q | wd;
                RG_DCLR: dout_q      <= dout_q & ~wd;
                RG_LLO:  cfg_q.lvl_lo <= wd;
                RG_LHI:  cfg_q.lvl_hi <= wd;
                RG_RISE: cfg_q.rise  <= wd;
                RG_FALL: cfg_q.fall  <= wd;
                default: ;
            endcase
        end
    end

    pin_bank_sync u_sync (
        .clk (clk),
        .rst (rst),
        .din (pad_in),
        .smp (smp)
    );

    pin_bank_detect u_detect (
        .cfg (cfg_q),
        .smp (smp),
        .evt (evt)
    );

    for (genvar n = 0; n < NLINE; n++) begin : g_line
        pin_bank_irq_line #(.LINE(n)) u_line (
            .clk    (clk),
            .rst    (rst),
            .addr   (bus_addr),
            .wr     (bus_wr),
            .wdata  (wd),
            .evt    (evt),
            .rd_hit (line_hit[n]),
            .rd_val (line_val[n]),
            .irq    (irq_o[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RG_REV:  bus_rdata = REV_VALUE;
            RG_OE:   bus_rdata = 32'(oe_q);
            RG_DIN:  bus_rdata = 32'(smp.cur);
            RG_DOUT: bus_rdata = 32'(dout_q);
            RG_LLO:  bus_rdata = 32'(cfg_q.lvl_lo);
            RG_LHI:  bus_rdata = 32'(cfg_q.lvl_hi);
            RG_RISE: bus_rdata = 32'(cfg_q.rise);
            RG_FALL: bus_rdata = 32'(cfg_q.fall);
            default: begin
                for (int n = 0; n < NLINE; n++)
                    if (line_hit[n]) bus_rdata = bus_rdata | 32'(line_val[n]);
            end
        endcase
    end

    assign pad_out  = dout_q;
    assign pad_oe_n = oe_q;

    // R3: set alias raises the written bits
    assert_dout_set_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == RG_DSET) |=> ((pad_out & $past(wd)) == $past(wd)));

    // R3: clear alias drops the written bits and keeps the others
    assert_dout_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == RG_DCLR) |=> (pad_out == ($past(pad_out) & ~$past(wd))));

    // R2: direction changes only through its own register
    assert_oe_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel == RG_OE) |=> $stable(pad_oe_n));

endmodule

// File: tb/sim_pin_bank_ctrl.sv
`timescale 1ns/1ps
module sim_pin_bank_ctrl;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 pad_out, 3 pad_oe_n
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe_n;
    logic [1:0]  irq_o;

    item_t q[$];
    item_t it;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    pin_bank_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe_n(pad_oe_n), .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares them with the outputs
    always @(negedge clk) begin
        while (q.size() > 0) begin
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                1:       act = {30'b0, irq_o};
                2:       act = pad_out;
                3:       act = pad_oe_n;
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [6:0] a,
                       input logic [31:0] e, input string tag);
        item_t n;
        @(posedge clk); #2;
        bus_addr = a; bus_wr = 1'b0;
        n.kind = kind; n.exp = e; n.tag = tag;
        q.push_back(n);
        @(negedge clk); #1;
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(posedge clk); #2;
        pad_in = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // Reset state
        chk(0, 7'h00, 32'h5060_0801, "R1 revision");
        chk(0, 7'h4D, 32'hFFFF_FFFF, "R2 direction reset");
        chk(3, 7'h00, 32'hFFFF_FFFF, "R2 pad_oe_n reset");
        chk(0, 7'h4F, 32'h0, "R3 latch reset");
        chk(0, 7'h09, 32'h0, "R6 raw0 reset");
        chk(1, 7'h00, 32'h0, "R6 irq reset");
        chk(0, 7'h0D, 32'h0, "R9 enable0 reset");

        wr(7'h00, 32'h1234_5678);
        chk(0, 7'h00, 32'h5060_0801, "R1 revision after write");

        wr(7'h4D, 32'hFFFF_0000);
        chk(0, 7'h4D, 32'hFFFF_0000, "R2 direction readback");
        chk(3, 7'h00, 32'hFFFF_0000, "R2 pad_oe_n");

        // Output latch aliases
        wr(7'h65, 32'h0000_00F0);
        chk(0, 7'h4F, 32'h0000_00F0, "R3 set alias");
        wr(7'h64, 32'h0000_0030);
        chk(0, 7'h4F, 32'h0000_00C0, "R3 clear alias");
        wr(7'h65, 32'h0);
        chk(2, 7'h00, 32'h0000_00C0, "R3 zero set keeps latch");
        wr(7'h4F, 32'h8000_0001);
        chk(2, 7'h00, 32'h8000_0001, "R3 direct write");

        // Synchronized input
        set_pad(32'h0000_00A5);
        chk(0, 7'h4E, 32'h0000_00A5, "R4 data-in");
        set_pad(32'h0);
        chk(0, 7'h4E, 32'h0, "R4 data-in low");
        chk(0, 7'h09, 32'h0, "R5 no detect enabled");

        // Rising edge on pin 0, line 0 enabled
        wr(7'h52, 32'h1);
        wr(7'h0D, 32'h1);
        set_pad(32'h1);
        chk(0, 7'h09, 32'h1, "R5 rising raw0");
        chk(0, 7'h0B, 32'h1, "R6 masked0");
        chk(1, 7'h00, 32'h1, "R6 irq line0 only");
        chk(0, 7'h0A, 32'h1, "R6 raw1 without enable");
        chk(0, 7'h0C, 32'h0, "R6 masked1 zero");

        // Write-one-to-clear
        wr(7'h0B, 32'h0);
        chk(0, 7'h09, 32'h1, "R7 zero write keeps pending");
        wr(7'h0B, 32'h1);
        chk(0, 7'h09, 32'h0, "R7 clear raw0");
        chk(1, 7'h00, 32'h0, "R7 irq drops");
        chk(0, 7'h0A, 32'h1, "R7 line1 untouched");
        wr(7'h0A, 32'h1);
        chk(0, 7'h0A, 32'h1, "R7 raw write ignored");
        wr(7'h0C, 32'h1);
        chk(0, 7'h0A, 32'h0, "R7 clear raw1");

        // Falling edge on pin 1
        wr(7'h53, 32'h2);
        set_pad(32'h3);
        chk(0, 7'h09, 32'h0, "R5 no fall on rise");
        set_pad(32'h1);
        chk(0, 7'h09, 32'h2, "R5 falling raw0");
        chk(1, 7'h00, 32'h0, "R6 irq masked off");
        wr(7'h0B, 32'h2);
        wr(7'h0C, 32'h2);

        // High level on pin 2 re-pends after clear
        wr(7'h51, 32'h4);
        set_pad(32'h5);
        chk(0, 7'h09, 32'h4, "R5 high level raw0");
        wr(7'h0B, 32'h4);
        chk(0, 7'h09, 32'h4, "R8 level re-pends");
        wr(7'h0E, 32'h4);
        chk(1, 7'h00, 32'h2, "R6 irq line1 only");
        set_pad(32'h1);
        wr(7'h0B, 32'h4);
        wr(7'h0C, 32'h4);
        chk(0, 7'h09, 32'h0, "R8 cleared once level gone");
        chk(1, 7'h00, 32'h0, "R8 irq quiet");

        // Enable aliases
        wr(7'h0E, 32'hF);
        wr(7'h10, 32'h3);
        chk(0, 7'h0E, 32'hC, "R9 enable1 via set word");
        chk(0, 7'h10, 32'hC, "R9 enable1 via clear word");
        chk(0, 7'h0D, 32'h1, "R9 enable0 untouched");

        // Low level on pin 3
        wr(7'h50, 32'h8);
        chk(0, 7'h09, 32'h8, "R5 low level raw0");
        set_pad(32'h9);
        wr(7'h0B, 32'h8);
        wr(7'h0C, 32'h8);
        chk(0, 7'h09, 32'h0, "R5 low level cleared");

        // Combined types and switching on pin 4
        wr(7'h52, 32'h11);
        wr(7'h53, 32'h12);
        set_pad(32'h19);
        chk(0, 7'h09, 32'h10, "R10 rise with fall also on");
        wr(7'h0B, 32'h10);
        set_pad(32'h09);
        chk(0, 7'h09, 32'h10, "R10 fall with rise also on");
        wr(7'h0B, 32'h10);
        chk(0, 7'h09, 32'h0, "R10 cleared");
        wr(7'h51, 32'h14);
        wr(7'h52, 32'h1);
        wr(7'h53, 32'h2);
        set_pad(32'h19);
        chk(0, 7'h09, 32'h10, "R10 level after switch");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule